// File: doc/BRIEF.md
# Dual-Bank Ping-Pong Register File

This block is an 18-bit register file split into two banks of 32 words. A single role bit decides which bank is the compute bank and which is the transfer bank. The compute bank has three synchronous read ports that supply the a, b and c operands of a multiply-accumulate `d = a*b + c`, and one write port that takes results back. The transfer bank is carved into four aligned 8-word regions. A whole region is written from, or read onto, a 144-bit block bus, for traffic to and from data memory.

Because the two banks have separate write ports, a block transfer into the transfer bank runs in the same cycle as operand reads and a result write on the compute bank. Once a group of operands has been staged, a swap command exchanges the roles. The freshly loaded bank then feeds the arithmetic, and the bank just used for compute becomes available for storing results out and loading the next group. A swap is refused while block traffic is still in flight.

Top module: `rf_pingpong`

## Requirements
- R1: After reset, `cmp_bank` is 0 (bank 0 computes), `blk_rd_valid` is 0, and every entry of both banks reads as zero on both the word ports and the block port.
- R2: Each of the three read ports returns the compute-bank word at its address in the cycle after the address is presented. The three ports take independent addresses.
- R3: A write with `wr_en` high stores `wr_data` at `wr_addr` of the compute bank only. A read in any later cycle returns the new value, and the transfer bank is unchanged.
- R4: A block write with `blk_wr_en` high stores the 144-bit bus into region r of the transfer bank in one cycle. Region r covers entries 8r to 8r+7, and word i of the region sits at bus bits 18i+17:18i. The compute bank is unchanged.
- R5: A block read with `blk_rd_en` high returns region r of the transfer bank on `blk_rd_data`, with the same word layout as R4, one cycle later. `blk_rd_valid` is high in exactly that cycle.
- R6: `swap_req` with `busy` low flips `cmp_bank` at the next clock edge. Data written through either path stays in its physical bank, so the former transfer bank's contents then appear on the read ports and the former compute bank's contents on the block port.
- R7: `busy` is high while `blk_wr_en` or `blk_rd_en` is high, or while a block read result is still pending from the previous cycle. `swap_req` while `busy` is high is dropped, and `cmp_bank` keeps its value.
- R8: A result write and a block write issued in the same cycle both take effect, each in its own bank.
- R9: A read and a write to the same compute-bank address in the same cycle return the old data. The new data appears on the following read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_req | input | 1 | Request to exchange bank roles |
| cmp_bank | output | 1 | Index of the current compute bank |
| busy | output | 1 | Block traffic in flight; swap refused |
| rd_addr_a | input | 5 | Operand a address |
| rd_addr_b | input | 5 | Operand b address |
| rd_addr_c | input | 5 | Operand c address |
| rd_data_a | output | 18 | Operand a data, one cycle latency |
| rd_data_b | output | 18 | Operand b data, one cycle latency |
| rd_data_c | output | 18 | Operand c data, one cycle latency |
| wr_en | input | 1 | Result write enable |
| wr_addr | input | 5 | Result write address |
| wr_data | input | 18 | Result write data |
| blk_wr_en | input | 1 | Block write enable |
| blk_wr_region | input | 2 | Block write region |
| blk_wr_data | input | 144 | Block write data, word i at bits 18i+17:18i |
| blk_rd_en | input | 1 | Block read enable |
| blk_rd_region | input | 2 | Block read region |
| blk_rd_data | output | 144 | Block read data |
| blk_rd_valid | output | 1 | Block read data valid |

## Verification
The bench builds the block with the package defaults: 18-bit words, 32 entries per bank and 8-word regions. With these values all 32 addresses on each port and all four region boundaries can be swept exhaustively. A model of both physical banks and the role bit predicts every word and block result. The sequence covers refused swaps against block writes, block reads and a pending read result, and then a granted swap. After the swap the data written earlier must show up behind the other port.

// File: rtl/rf_pkg.sv
package rf_pkg;
    parameter int WORD_W    = 18;
    parameter int DEPTH     = 32;
    parameter int BLK_WORDS = 8;
    parameter int N_RD      = 3;

    localparam int ADDR_W   = $clog2(DEPTH);
    localparam int OFF_W    = $clog2(BLK_WORDS);
    localparam int REGIONS  = DEPTH / BLK_WORDS;
    localparam int REGION_W = $clog2(REGIONS);
    localparam int BLK_W    = WORD_W * BLK_WORDS;

    typedef logic [WORD_W-1:0]                   word_t;
    typedef logic [ADDR_W-1:0]                   addr_t;
    typedef logic [REGION_W-1:0]                 region_t;
    typedef logic [BLK_WORDS-1:0][WORD_W-1:0]    blk_t;
    typedef logic [DEPTH-1:0][WORD_W-1:0]        img_t;

    typedef enum logic {
        BANK0 = 1'b0,
        BANK1 = 1'b1
    } bank_sel_t;

    function automatic bank_sel_t other_bank(bank_sel_t b);
        return (b == BANK0) ? BANK1 : BANK0;
    endfunction
endpackage

// File: rtl/rf_bank.sv
module rf_bank
    import rf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we_word,
    input  addr_t   waddr,
    input  word_t   wdata,
    input  logic    we_blk,
    input  region_t region,
    input  blk_t    blk,
    output img_t    img
);
    img_t img_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            img_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (we_word && waddr == ADDR_W'(i)) begin
                    img_q[i] <= wdata;
                end else if (we_blk && region == REGION_W'(i / BLK_WORDS)) begin
                    img_q[i] <= blk[i % BLK_WORDS];
                end
            end
        end
    end

    assign img = img_q;

    // R8: the role decode must never give one bank both writers
    assert_single_writer_R8: assert property (@(posedge clk) disable iff (rst)
        !(we_word && we_blk));
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  addr_t     addr,
    input  img_t      img0,
    input  img_t      img1,
    input  bank_sel_t sel,
    output word_t     data
);
    word_t data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else begin
            data_q <= (sel == BANK0) ? img0[addr] : img1[addr];
        end
    end

    assign data = data_q;
endmodule

// File: rtl/rf_role_ctrl.sv
module rf_role_ctrl
    import rf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      swap_req,
    input  logic      blk_wr_en,
    input  logic      blk_rd_en,
    output bank_sel_t mode,
    output logic      busy
);
    bank_sel_t mode_q;
    logic      rd_pend_q;

    assign busy = blk_wr_en | blk_rd_en | rd_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= BANK0;
            rd_pend_q <= 1'b0;
        end else begin
            rd_pend_q <= blk_rd_en;
            if (swap_req && !busy) begin
                mode_q <= other_bank(mode_q);
            end
        end
    end

    assign mode = mode_q;

    assert_swap_flips_R6: assert property (@(posedge clk) disable iff (rst)
        (swap_req && !busy) |=> (mode != $past(mode)));

    assert_swap_refused_R7: assert property (@(posedge clk) disable iff (rst)
        (swap_req && busy) |=> (mode == $past(mode)));

    assert_mode_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !swap_req |=> $stable(mode));

    assert_busy_traffic_R7: assert property (@(posedge clk) disable iff (rst)
        (blk_wr_en || blk_rd_en) |-> busy);
endmodule

// File: rtl/rf_pingpong.sv
module rf_pingpong
    import rf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                swap_req,
    output logic                cmp_bank,
    output logic                busy,
    input  logic [ADDR_W-1:0]   rd_addr_a,
    input  logic [ADDR_W-1:0]   rd_addr_b,
    input  logic [ADDR_W-1:0]   rd_addr_c,
    output logic [WORD_W-1:0]   rd_data_a,
    output logic [WORD_W-1:0]   rd_data_b,
    output logic [WORD_W-1:0]   rd_data_c,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                blk_wr_en,
    input  logic [REGION_W-1:0] blk_wr_region,
    input  logic [BLK_W-1:0]    blk_wr_data,
    input  logic                blk_rd_en,
    input  logic [REGION_W-1:0] blk_rd_region,
    output logic [BLK_W-1:0]    blk_rd_data,
    output logic                blk_rd_valid
);
    bank_sel_t mode;
    img_t      img [2];
    blk_t      blk_in;
    addr_t     rd_addr [N_RD];
    word_t     rd_data [N_RD];

    assign blk_in = blk_wr_data;

    rf_role_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .swap_req  (swap_req),
        .blk_wr_en (blk_wr_en),
        .blk_rd_en (blk_rd_en),
        .mode      (mode),
        .busy      (busy)
    );

    assign cmp_bank = mode;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic is_cmp;
        assign is_cmp = (mode == bank_sel_t'(1'(b)));
        rf_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .we_word (wr_en && is_cmp),
            .waddr   (wr_addr),
            .wdata   (wr_data),
            .we_blk  (blk_wr_en && !is_cmp),
            .region  (blk_wr_region),
            .blk     (blk_in),
            .img     (img[b])
        );
    end

    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;
    assign rd_addr[2] = rd_addr_c;

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        rf_read_port u_rd (
            .clk  (clk),
            .rst  (rst),
            .addr (rd_addr[p]),
            .img0 (img[0]),
            .img1 (img[1]),
            .sel  (mode),
            .data (rd_data[p])
        );
    end

    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];
    assign rd_data_c = rd_data[2];

    // block read path from the transfer bank
    img_t xfer_img;
    blk_t blk_nxt;
    blk_t blk_q;
    logic blk_v_q;

    assign xfer_img = (mode == BANK0) ? img[1] : img[0];

    for (genvar w = 0; w < BLK_WORDS; w++) begin : g_bword
        assign blk_nxt[w] = xfer_img[{blk_rd_region, OFF_W'(w)}];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q   <= '0;
            blk_v_q <= 1'b0;
        end else begin
            blk_v_q <= blk_rd_en;
            if (blk_rd_en) begin
                blk_q <= blk_nxt;
            end
        end
    end

    assign blk_rd_data  = blk_q;
    assign blk_rd_valid = blk_v_q;

    assert_blk_valid_R5: assert property (@(posedge clk) disable iff (rst)
        blk_rd_en |=> blk_rd_valid);

    assert_blk_valid_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !blk_rd_en |=> !blk_rd_valid);

    assert_pending_busy_R7: assert property (@(posedge clk) disable iff (rst)
        blk_rd_valid |-> busy);
endmodule

// File: tb/test_rf_pingpong.sv
`timescale 1ns/100ps
module test_rf_pingpong;
    import rf_pkg::*;

    logic                clk = 1'b0;
    logic                rst;
    logic                swap_req;
    logic                cmp_bank;
    logic                busy;
    logic [ADDR_W-1:0]   rd_addr_a, rd_addr_b, rd_addr_c;
    logic [WORD_W-1:0]   rd_data_a, rd_data_b, rd_data_c;
    logic                wr_en;
    logic [ADDR_W-1:0]   wr_addr;
    logic [WORD_W-1:0]   wr_data;
    logic                blk_wr_en;
    logic [REGION_W-1:0] blk_wr_region;
    logic [BLK_W-1:0]    blk_wr_data;
    logic                blk_rd_en;
    logic [REGION_W-1:0] blk_rd_region;
    logic [BLK_W-1:0]    blk_rd_data;
    logic                blk_rd_valid;

    always #2 clk = ~clk;   // 250 MHz

    rf_pingpong i_rf_pingpong (
        .clk           (clk),
        .rst           (rst),
        .swap_req      (swap_req),
        .cmp_bank      (cmp_bank),
        .busy          (busy),
        .rd_addr_a     (rd_addr_a),
        .rd_addr_b     (rd_addr_b),
        .rd_addr_c     (rd_addr_c),
        .rd_data_a     (rd_data_a),
        .rd_data_b     (rd_data_b),
        .rd_data_c     (rd_data_c),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .blk_wr_en     (blk_wr_en),
        .blk_wr_region (blk_wr_region),
        .blk_wr_data   (blk_wr_data),
        .blk_rd_en     (blk_rd_en),
        .blk_rd_region (blk_rd_region),
        .blk_rd_data   (blk_rd_data),
        .blk_rd_valid  (blk_rd_valid)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    typedef struct {
        int           sel;
        logic [BLK_W-1:0] exp;
        string        tag;
    } item_t;
    item_t sb[$];

    // reference model of both physical banks and the role bit
    logic [WORD_W-1:0] mdl [2][DEPTH];
    int  m_mode = 0;
    bit  m_pend = 0;

    function automatic void check(string tag, string what,
                                  logic [BLK_W-1:0] act, logic [BLK_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endfunction

    function automatic logic [WORD_W-1:0] pat(int k);
        return WORD_W'((k * 7919 + 12345) ^ (k << 9));
    endfunction

    // monitor: compares design outputs one time unit after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                case (it.sel)
                    0: check(it.tag, "rd_data_a", BLK_W'(rd_data_a), it.exp);
                    1: check(it.tag, "rd_data_b", BLK_W'(rd_data_b), it.exp);
                    2: check(it.tag, "rd_data_c", BLK_W'(rd_data_c), it.exp);
                    3: check(it.tag, "blk_rd_data", blk_rd_data, it.exp);
                    4: check(it.tag, "cmp_bank", BLK_W'(cmp_bank), it.exp);
                    default: check(it.tag, "blk_rd_valid", BLK_W'(blk_rd_valid), it.exp);
                endcase
            end
        end
    end

    function automatic void push(int sel, logic [BLK_W-1:0] exp, string tag);
        item_t it;
        it.sel = sel;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
    endfunction

    task automatic idle();
        swap_req  = 0;
        wr_en     = 0;
        blk_wr_en = 0;
        blk_rd_en = 0;
    endtask

    // driver: called at a falling edge with inputs set; predicts, then advances
    task automatic tick(string tag, bit ca, bit cb, bit cc);
        bit exp_busy;
        logic [BLK_W-1:0] bexp;
        #1;
        exp_busy = blk_wr_en || blk_rd_en || m_pend;
        check(tag, "busy", BLK_W'(busy), BLK_W'(exp_busy));
        if (ca) push(0, BLK_W'(mdl[m_mode][rd_addr_a]), tag);
        if (cb) push(1, BLK_W'(mdl[m_mode][rd_addr_b]), tag);
        if (cc) push(2, BLK_W'(mdl[m_mode][rd_addr_c]), tag);
        if (blk_rd_en) begin
            for (int w = 0; w < BLK_WORDS; w++)
                bexp[w*WORD_W +: WORD_W] = mdl[1-m_mode][int'(blk_rd_region)*BLK_WORDS + w];
            push(3, bexp, tag);
        end
        push(5, BLK_W'(blk_rd_en), tag);
        if (wr_en) mdl[m_mode][wr_addr] = wr_data;
        if (blk_wr_en)
            for (int w = 0; w < BLK_WORDS; w++)
                mdl[1-m_mode][int'(blk_wr_region)*BLK_WORDS + w] = blk_wr_data[w*WORD_W +: WORD_W];
        if (swap_req && !exp_busy) m_mode = 1 - m_mode;
        m_pend = blk_rd_en;
        push(4, BLK_W'(m_mode), tag);
        @(negedge clk);
        idle();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < DEPTH; i++) mdl[b][i] = '0;
        idle();
        rd_addr_a = '0; rd_addr_b = '0; rd_addr_c = '0;
        wr_addr = '0; wr_data = '0;
        blk_wr_region = '0; blk_wr_data = '0; blk_rd_region = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check("R1", "cmp_bank", BLK_W'(cmp_bank), '0);
        check("R1", "blk_rd_valid", BLK_W'(blk_rd_valid), '0);
        @(negedge clk);

        // R1: all entries zero after reset, word and block ports
        for (int i = 0; i < DEPTH; i++) begin
            rd_addr_a = ADDR_W'(i); rd_addr_b = ADDR_W'(i + 1); rd_addr_c = ADDR_W'(i + 2);
            tick("R1", 1, 1, 1);
        end
        for (int r = 0; r < REGIONS; r++) begin
            blk_rd_en = 1; blk_rd_region = REGION_W'(r);
            tick("R1", 0, 0, 0);
        end

        // R3: result writes into the compute bank
        for (int i = 0; i < DEPTH; i++) begin
            wr_en = 1; wr_addr = ADDR_W'(i); wr_data = pat(i);
            tick("R3", 0, 0, 0);
        end
        // R2: three independent read ports
        for (int i = 0; i < DEPTH; i++) begin
            rd_addr_a = ADDR_W'(i); rd_addr_b = ADDR_W'(DEPTH - 1 - i); rd_addr_c = ADDR_W'(i * 5);
            tick("R2", 1, 1, 1);
        end
        // R3: transfer bank untouched by result writes
        blk_rd_en = 1; blk_rd_region = 2;
        tick("R3", 0, 0, 0);

        // R9: same-cycle read and write of one address
        wr_en = 1; wr_addr = 5; wr_data = 18'h2AAAA; rd_addr_a = 5;
        tick("R9", 1, 0, 0);
        rd_addr_a = 5;
        tick("R9", 1, 0, 0);

        // R4: block writes to every region of the transfer bank
        for (int r = 0; r < REGIONS; r++) begin
            blk_wr_en = 1; blk_wr_region = REGION_W'(r);
            for (int w = 0; w < BLK_WORDS; w++)
                blk_wr_data[w*WORD_W +: WORD_W] = pat(100 + r * BLK_WORDS + w);
            tick("R4", 0, 0, 0);
        end
        for (int i = 0; i < DEPTH; i++) begin
            rd_addr_a = ADDR_W'(i); rd_addr_b = ADDR_W'(i ^ 7); rd_addr_c = ADDR_W'(i ^ 24);
            tick("R4", 1, 1, 1);
        end

        // R5: block reads in a shuffled region order, with idle gaps
        blk_rd_en = 1; blk_rd_region = 3; tick("R5", 0, 0, 0);
        tick("R5", 0, 0, 0);
        blk_rd_en = 1; blk_rd_region = 0; tick("R5", 0, 0, 0);
        blk_rd_en = 1; blk_rd_region = 2; tick("R5", 0, 0, 0);
        blk_rd_en = 1; blk_rd_region = 1; tick("R5", 0, 0, 0);
        tick("R5", 0, 0, 0);

        // R8: result write and block write in the same cycle
        wr_en = 1; wr_addr = 9; wr_data = pat(500);
        blk_wr_en = 1; blk_wr_region = 1;
        for (int w = 0; w < BLK_WORDS; w++)
            blk_wr_data[w*WORD_W +: WORD_W] = pat(600 + w);
        tick("R8", 0, 0, 0);
        rd_addr_a = 9; blk_rd_en = 1; blk_rd_region = 1;
        tick("R8", 1, 0, 0);

        // R7: swaps refused under block traffic and a pending read
        swap_req = 1; tick("R7", 0, 0, 0);          // read result still pending
        swap_req = 1; blk_wr_en = 1; blk_wr_region = 0;
        for (int w = 0; w < BLK_WORDS; w++)
            blk_wr_data[w*WORD_W +: WORD_W] = pat(700 + w);
        tick("R7", 0, 0, 0);
        swap_req = 1; blk_rd_en = 1; blk_rd_region = 0; tick("R7", 0, 0, 0);
        swap_req = 1; rd_addr_a = 0; tick("R7", 1, 0, 0);

        // R6: granted swap, data follows its physical bank
        swap_req = 1; tick("R6", 0, 0, 0);
        for (int i = 0; i < DEPTH; i++) begin
            rd_addr_a = ADDR_W'(i); rd_addr_b = ADDR_W'(i + 3); rd_addr_c = ADDR_W'(i + 17);
            tick("R6", 1, 1, 1);
        end
        for (int r = 0; r < REGIONS; r++) begin
            blk_rd_en = 1; blk_rd_region = REGION_W'(r);
            tick("R6", 0, 0, 0);
        end
        tick("R6", 0, 0, 0);
        wr_en = 1; wr_addr = 31; wr_data = pat(900);
        tick("R6", 0, 0, 0);
        swap_req = 1; tick("R6", 0, 0, 0);
        rd_addr_a = 31; rd_addr_b = 5; rd_addr_c = 9;
        blk_rd_en = 1; blk_rd_region = 3;
        tick("R6", 1, 1, 1);
        tick("R6", 0, 0, 0);

        @(negedge clk);
        if (sb.size() != 0) begin
            n_errors++;
            $display("FAIL scoreboard: got %0d items left expected 0", sb.size());
        end
        summary();
    end
endmodule